// File: doc/BRIEF.md
# Matrix Keypad Scanner and Encoder

This block reads a 16-key matrix keypad laid out as four rows and four columns. It raises one row line at a time and keeps it high for a set number of clocks. At the end of that window it reads the four column lines to see which keys join that row. One full pass over the four rows is a scan. Each scan yields at most one key. The block turns that key into a single hex digit.

A key is accepted only after the same scan result has been seen on several consecutive scans, which filters out contact bounce. When a key is accepted, its code goes to the output and a one-clock strobe marks the new press. The code then stays on the output until a different press is accepted. The column inputs are asynchronous to the clock and are synchronized inside the block. The keypad needs external pull-downs, so that a column that no key joins reads low.

Top module: `keypad_scan_enc`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets row_o to 4'b0001, key_code_o to 0 and key_valid_o to 0. After reset is released, the scan restarts at row 0.
- R2: Exactly one bit of row_o is high at any time, and bit i drives row i. Each row stays high for DWELL_CYCLES clocks. The rows follow the order 0, 1, 2, 3 and then repeat, so after k clocks from the release of reset the high row is (k / DWELL_CYCLES) mod 4.
- R3: The key joining row r with column c (col_i[c]) has this code. Row 0 holds 1, 2, 3, A. Row 1 holds 4, 5, 6, B. Row 2 holds 7, 8, 9, C. Row 3 holds star, 0, hash, D. Each row is listed from column 0 to column 3.
- R4: The star key (row 3, column 0) gives code 4'hE. The hash key (row 3, column 2) gives code 4'hF.
- R5: A key is accepted only after it reads the same on STABLE_SCANS consecutive scans. A press too short for that gives no strobe and leaves key_code_o unchanged.
- R6: key_valid_o is high for exactly one clock on each newly accepted press. A key that is held gives one strobe. Pressing the same key again after a release, or moving straight to a different key, gives a new strobe.
- R7: When several columns read high for the same row, the lowest-numbered column sets the code.
- R8: key_code_o keeps the last accepted code until another press is accepted, including after the key is released.
- R9: When keys in more than one row are down at once, the key in the row scanned first in the pass (the lowest row) wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| col_i | input | 4 | Column sense lines, asynchronous, high when a key joins the driven row |
| row_o | output | 4 | Row drive lines, one high at a time |
| key_code_o | output | 4 | Hex code of the last accepted key |
| key_valid_o | output | 1 | One-clock strobe on each accepted press |

## Verification
The hardest cases to reach from the ports are the ones that depend on where a press falls relative to the scan. These are a press that is too short to survive the filter, two keys that are down together, and a change from one held key to another with no release in between. The bench models the keypad as a set of switches. Each column input is derived from whichever row the design is currently driving, so every timing relation with the scan appears on its own. The tasks then choose hold lengths in whole scans, or below one scan, to land in each of these cases.

// File: rtl/kp_pkg.sv
package kp_pkg;
    localparam int NUM_ROWS = 4;
    localparam int NUM_COLS = 4;
    localparam int RW = $clog2(NUM_ROWS);
    localparam int CW = $clog2(NUM_COLS);

    typedef struct packed {
        logic       found;
        logic [3:0] code;
    } scan_res_t;

    // Hex code of the key at row r, column c of the keypad.
    function automatic logic [3:0] key_code(logic [RW-1:0] r, logic [CW-1:0] c);
        logic [3:0] rr;
        logic [3:0] cc;
        rr = {{(4-RW){1'b0}}, r};
        cc = {{(4-CW){1'b0}}, c};
        if (cc == 4'd3)
            return 4'hA + rr;
        else if (rr == 4'd3)
            return (cc == 4'd0) ? 4'hE : (cc == 4'd1) ? 4'h0 : 4'hF;
        else
            return rr * 4'd3 + cc + 4'd1;
    endfunction
endpackage

// File: rtl/kp_row_sequencer.sv
module kp_row_sequencer
    import kp_pkg::*;
#(
    parameter int DWELL_CYCLES = 4
) (
    input  logic                clk,
    input  logic                rst,
    output logic [NUM_ROWS-1:0] row_o,
    output logic [RW-1:0]       row_idx_o,
    output logic                sample_o,
    output logic                last_row_o
);
    localparam int DCW = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;
    localparam logic [DCW-1:0] DWELL_LAST = DCW'(DWELL_CYCLES - 1);
    localparam logic [RW-1:0]  ROW_LAST   = RW'(NUM_ROWS - 1);

    typedef struct packed {
        logic [DCW-1:0] cnt;
        logic [RW-1:0]  idx;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == DWELL_LAST) begin
            st_d.cnt = '0;
            st_d.idx = (st_q.idx == ROW_LAST) ? '0 : st_q.idx + 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
        assign row_o[g] = (st_q.idx == RW'(g));
    end

    assign row_idx_o  = st_q.idx;
    assign sample_o   = (st_q.cnt == DWELL_LAST);
    assign last_row_o = sample_o && (st_q.idx == ROW_LAST);

    // R2: at the end of a dwell, the drive moves to the next row in rotation.
    a_r2_row_advance: assert property (@(posedge clk) disable iff (rst)
        sample_o |=> (row_o == {$past(row_o[NUM_ROWS-2:0]), $past(row_o[NUM_ROWS-1])}));
    // R2: inside a dwell, the drive does not move.
    a_r2_row_hold: assert property (@(posedge clk) disable iff (rst)
        !sample_o |=> $stable(row_o));
endmodule

// File: rtl/kp_col_sync.sv
module kp_col_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta   = async_i;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign sync_o = s_q.stable;
endmodule

// File: rtl/kp_key_filter.sv
module kp_key_filter
    import kp_pkg::*;
#(
    parameter int STABLE_SCANS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_i,
    input  logic                last_row_i,
    input  logic [RW-1:0]       row_idx_i,
    input  logic [NUM_COLS-1:0] cols_i,
    output logic [3:0]          code_o,
    output logic                valid_o
);
    localparam int SCW = $clog2(STABLE_SCANS + 1);
    localparam logic [SCW-1:0] STABLE_N = SCW'(STABLE_SCANS);

    typedef struct packed {
        scan_res_t      frame;
        scan_res_t      cand;
        logic [SCW-1:0] cnt;
        scan_res_t      held;
        logic [3:0]     code;
        logic           valid;
    } filt_t;

    filt_t f_d, f_q;
    scan_res_t cur;
    logic [CW-1:0] low_col;

    always_comb begin
        low_col = '0;
        for (int j = NUM_COLS - 1; j >= 0; j--)
            if (cols_i[j]) low_col = CW'(j);
    end

    always_comb begin
        f_d       = f_q;
        f_d.valid = 1'b0;
        cur       = f_q.frame;
        if (sample_i && !cur.found && (|cols_i)) begin
            cur.found = 1'b1;
            cur.code  = key_code(row_idx_i, low_col);
        end
        if (sample_i) begin
            if (last_row_i) begin
                f_d.frame = '0;
                if (cur == f_q.cand) begin
                    if (f_q.cnt != STABLE_N) f_d.cnt = f_q.cnt + 1'b1;
                end else begin
                    f_d.cand = cur;
                    f_d.cnt  = SCW'(1);
                end
                if (f_d.cnt == STABLE_N && f_d.cand != f_q.held) begin
                    f_d.held = f_d.cand;
                    if (f_d.cand.found) begin
                        f_d.code  = f_d.cand.code;
                        f_d.valid = 1'b1;
                    end
                end
            end else begin
                f_d.frame = cur;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) f_q <= '0;
        else     f_q <= f_d;
    end

    assign code_o  = f_q.code;
    assign valid_o = f_q.valid;

    // R6: the strobe never lasts more than one clock.
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);
    // R8: the code changes only together with a strobe.
    a_r8_code_held: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (valid_o || $stable(code_o)));
    // R5: a strobe only follows the end of a complete scan.
    a_r5_after_scan: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(last_row_i));
endmodule

// File: rtl/keypad_scan_enc.sv
module keypad_scan_enc
    import kp_pkg::*;
#(
    parameter int DWELL_CYCLES = 4,
    parameter int STABLE_SCANS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] col_i,
    output logic [3:0] row_o,
    output logic [3:0] key_code_o,
    output logic       key_valid_o
);
    logic [RW-1:0]       row_idx;
    logic                sample;
    logic                last_row;
    logic [NUM_COLS-1:0] cols_s;

    kp_row_sequencer #(.DWELL_CYCLES(DWELL_CYCLES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .row_o      (row_o),
        .row_idx_o  (row_idx),
        .sample_o   (sample),
        .last_row_o (last_row)
    );

    kp_col_sync #(.WIDTH(NUM_COLS)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (col_i),
        .sync_o  (cols_s)
    );

    kp_key_filter #(.STABLE_SCANS(STABLE_SCANS)) u_filt (
        .clk        (clk),
        .rst        (rst),
        .sample_i   (sample),
        .last_row_i (last_row),
        .row_idx_i  (row_idx),
        .cols_i     (cols_s),
        .code_o     (key_code_o),
        .valid_o    (key_valid_o)
    );

    // R1: reset puts the scan on row 0 and clears the code and the strobe.
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (row_o == 4'b0001 && key_code_o == 4'h0 && !key_valid_o));
endmodule

// File: tb/keypad_scan_enc_bench.sv
module keypad_scan_enc_bench;
    localparam int DWELL  = 4;
    localparam int STABLE = 2;
    localparam int FRAME  = 4 * DWELL;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] col_i;
    logic [3:0] row_o;
    logic [3:0] key_code_o;
    logic       key_valid_o;
    logic [15:0] keys = '0;   // bit r*4+c = key at row r, column c is down

    int tests = 0;
    int fails = 0;
    bit done  = 0;
    bit prev_valid = 0;
    logic [3:0] exp_q[$];
    logic [3:0] last_code = 4'h0;

    always #2 clk = ~clk;

    keypad_scan_enc #(.DWELL_CYCLES(DWELL), .STABLE_SCANS(STABLE)) u_keypad_scan_enc (
        .clk         (clk),
        .rst         (rst),
        .col_i       (col_i),
        .row_o       (row_o),
        .key_code_o  (key_code_o),
        .key_valid_o (key_valid_o)
    );

    // Switch-matrix model: a column is high when a down key joins it to the driven row.
    always_comb
        for (int c = 0; c < 4; c++)
            col_i[c] = |(row_o & {keys[12+c], keys[8+c], keys[4+c], keys[c]});

    function automatic logic [3:0] exp_code(int r, int c);
        logic [3:0] tbl [16] = '{4'h1, 4'h2, 4'h3, 4'hA,
                                 4'h4, 4'h5, 4'h6, 4'hB,
                                 4'h7, 4'h8, 4'h9, 4'hC,
                                 4'hE, 4'h0, 4'hF, 4'hD};
        return tbl[r*4+c];
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Monitor: every strobe pops the scoreboard.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (key_valid_o) begin
                check(!prev_valid, "R6 strobe width", 2, 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5/R6 unexpected strobe", key_code_o, 16);
                end else begin
                    logic [3:0] e;
                    e = exp_q.pop_front();
                    check(key_code_o == e, "R3/R4/R7/R9 code", key_code_o, e);
                    last_code = e;
                end
            end
            prev_valid <= key_valid_o;
        end
    end

    task automatic wait_frames(int n);
        repeat (n * FRAME) @(negedge clk);
    endtask

    // Driver: press a key set, push the expected code, release.
    task automatic press(logic [15:0] mask, bit expect_it, logic [3:0] e, int hold, string req);
        if (expect_it) exp_q.push_back(e);
        keys = mask;
        wait_frames(hold);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        keys = '0;
        wait_frames(6);
        check(key_code_o == last_code, "R8 code held after release", key_code_o, last_code);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(row_o == 4'b0001 && key_code_o == 0 && !key_valid_o, "R1 reset state",
              {row_o, key_code_o}, 8'h10);
        rst = 1'b0;
        // R2: row rotation from release of reset
        for (int k = 0; k < 40; k++) begin
            logic [3:0] er;
            er = 4'b0001 << ((k / DWELL) % 4);
            check(row_o == er, "R2 row drive", row_o, er);
            @(negedge clk);
        end
        // R3 / R4: every key in turn
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                press(16'(1) << (r*4+c), 1, exp_code(r, c), 6, "R3 key accepted");
        // R4: star and hash once more
        press(16'(1) << 12, 1, 4'hE, 6, "R4 star");
        press(16'(1) << 14, 1, 4'hF, 6, "R4 hash");
        // R5: press shorter than one scan: no strobe, code unchanged
        keys = 16'(1) << 5;
        repeat (10) @(negedge clk);
        keys = '0;
        wait_frames(6);
        check(key_code_o == 4'hF, "R5 short press ignored", key_code_o, 4'hF);
        // R7: row 1, columns 1 and 3 together -> 5
        press((16'(1) << 5) | (16'(1) << 7), 1, 4'h5, 6, "R7 lowest column");
        // R9: row 0 col 2 and row 2 col 0 -> 3
        press((16'(1) << 2) | (16'(1) << 8), 1, 4'h3, 6, "R9 lowest row");
        // R6: long hold gives one strobe, then direct change to another key
        exp_q.push_back(4'h7);
        keys = 16'(1) << 8;
        wait_frames(12);
        check(exp_q.size() == 0, "R6 held key single strobe", exp_q.size(), 0);
        press(16'(1) << 1, 1, 4'h2, 6, "R6 direct change");
        // R6: same key again after release
        press(16'(1) << 1, 1, 4'h2, 6, "R6 re-press same key");
        check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule